// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits between a set of peripheral sources and a CPU. Each source has one pending bit. That bit is set by a request pulse from the peripheral or by a software set strobe, and cleared by a software clear strobe or by the CPU's acknowledge. A per-source mask hides a pending bit from arbitration and from wake-up without erasing it. A per-source one-bit level, high or low, combined with a fixed index order, picks the single request presented to the CPU.

The controller holds the CPU's interrupt-enable bit itself. It remembers which levels are being serviced in a three-entry nesting stack (low, high, non-maskable). On acknowledge it pushes the serviced level and the enable value, then forces the enable off. A return strobe pops the stack and restores the enable value that was saved. A separate wake output tells a standby controller that an unmasked request is pending, even while interrupts are disabled.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Several request pulses on one source before acknowledge leave one pending bit. A single acknowledge clears it, and no further request follows.
- R2: `sw_set_i` and `sw_clr_i` change only the bits they name. When a set or request pulse and a clear target the same bit in the same cycle, the bit ends up set.
- R3: A masked pending bit produces neither a vector nor wake, but it stays set. Clearing its mask makes it active again in the next cycle.
- R4: `wake_o` is high whenever an unmasked pending bit or a pending non-maskable request exists, whatever the value of `ie_o`.
- R5: While `ie_o` is low, no maskable source is presented on `irq_o`.
- R6: Among unmasked pending sources, high-level sources (priority bit 1) win over low-level ones, and ties go to the lowest index. `vec_o` carries the winning index, or 0 when `irq_o` is low.
- R7: `ack_i` while `irq_o` is high clears the presented source's pending bit and forces `ie_o` low one cycle later. It also pushes the serviced level onto the nesting stack. `ack_i` while `irq_o` is low has no effect.
- R8: A maskable source is presented only if its level is strictly above the level in service, in the order none=0 < low=1 < high=2 < non-maskable=3. A high-level request preempts low service once the enable is set again.
- R9: A pending non-maskable request is presented with `vec_o` equal to N, regardless of mask and `ie_o`. While non-maskable service is active, nothing is presented.
- R10: `reti_i` pops the nesting stack and restores `ie_o` to its value before the matching acknowledge. A return with an empty stack is ignored. `ack_i` takes precedence over a `reti_i` in the same cycle.
- R11: After reset, all pending bits are clear, all masks are set, all levels are low, `ie_o` is low and the stack is empty. A request pulse then sets its bit but presents nothing and raises no wake.
- R12: `ie_clr_i` wins over `ie_set_i` in the same cycle. An accepted acknowledge wins over both, and so does a restore on return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pulse_i | input | N | Request pulses from the sources |
| sw_set_i | input | N | Software set strobes, one per pending bit |
| sw_clr_i | input | N | Software clear strobes, one per pending bit |
| mask_we_i | input | 1 | Writes the mask register |
| mask_wd_i | input | N | New mask value (1 = masked) |
| prio_we_i | input | 1 | Writes the level register |
| prio_wd_i | input | N | New level value (1 = high) |
| ie_set_i | input | 1 | Enables interrupts |
| ie_clr_i | input | 1 | Disables interrupts |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| reti_i | input | 1 | CPU return from service |
| nmi_i | input | 1 | Non-maskable request pulse |
| irq_o | output | 1 | Request presented to the CPU |
| vec_o | output | $clog2(N+1) | Index of the presented source, N for non-maskable |
| wake_o | output | 1 | Standby wake request |
| ie_o | output | 1 | CPU interrupt-enable state |
| flags_o | output | N | Pending bits |
| mask_o | output | N | Mask register |
| prio_o | output | N | Level register |
| isr_lvl_o | output | 2 | Level currently in service (0 none, 1 low, 2 high, 3 non-maskable) |
| isr_depth_o | output | 2 | Nesting depth |

## Verification
On every cycle the assertions check the following: a presented maskable source is unmasked, pending and enabled; no low-level winner is presented while a high-level source is eligible; and the in-service level blocks equal or lower requests. They also check that an unmasked pending bit always raises wake, that an accepted acknowledge drops the enable and deepens the stack, and that the reset state is correct. Only the scenarios can show the rest. This covers set-over-clear collisions, a masked bit surviving until unmask, and the exact enable value restored by each return in a three-deep nest. It also covers an empty-stack return being ignored and an acknowledge with nothing presented being ignored.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_NMI  = 2'd3
    } lvl_e;

    typedef struct packed {
        lvl_e lvl;
        logic ie;
    } isr_ent_t;

    localparam int ISR_DEPTH = 3;
    localparam int SP_W      = $clog2(ISR_DEPTH + 1);

    function automatic lvl_e level_of(input logic hi);
        return hi ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/pic_flag_bank.sv
module pic_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic         nmi_set,
    input  logic         nmi_clr,
    output logic [N-1:0] flags,
    output logic         nmi_pend
);
    logic [N-1:0] flags_q;
    logic         nmi_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    flags_q[g] <= 1'b0;
                else if (set_vec[g])
                    flags_q[g] <= 1'b1;
                else if (clr_vec[g])
                    flags_q[g] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            nmi_q <= 1'b0;
        else if (nmi_set)
            nmi_q <= 1'b1;
        else if (nmi_clr)
            nmi_q <= 1'b0;
    end

    assign flags    = flags_q;
    assign nmi_pend = nmi_q;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
    parameter int N  = 8,
    parameter int VW = $clog2(N + 1)
) (
    input  logic [N-1:0]  active,
    input  logic [N-1:0]  prio,
    output logic          win_valid,
    output logic          win_hi,
    output logic [VW-1:0] win_idx
);
    logic [N-1:0]  hi_set;
    logic [N-1:0]  pool;
    logic [VW-1:0] idx;

    assign hi_set = active & prio;
    assign pool   = (|hi_set) ? hi_set : active;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool[i])
                idx = VW'(i);
        end
    end

    assign win_valid = |active;
    assign win_hi    = |hi_set;
    assign win_idx   = idx;
endmodule

// File: rtl/pic_isr_stack.sv
module pic_isr_stack
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  isr_ent_t        push_ent,
    input  logic            pop,
    output isr_ent_t        top_ent,
    output logic [SP_W-1:0] depth
);
    isr_ent_t        ent_q [ISR_DEPTH];
    logic [SP_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (rst)
            sp_q <= '0;
        else if (push && sp_q != SP_W'(ISR_DEPTH))
            sp_q <= sp_q + 1'b1;
        else if (pop && sp_q != '0)
            sp_q <= sp_q - 1'b1;
    end

    generate
        for (genvar j = 0; j < ISR_DEPTH; j++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst)
                    ent_q[j] <= '{lvl: LVL_NONE, ie: 1'b0};
                else if (push && sp_q == SP_W'(j))
                    ent_q[j] <= push_ent;
            end
        end
    endgenerate

    always_comb begin
        top_ent = '{lvl: LVL_NONE, ie: 1'b0};
        for (int j = 0; j < ISR_DEPTH; j++) begin
            if (sp_q == SP_W'(j + 1))
                top_ent = ent_q[j];
        end
    end

    assign depth = sp_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_pulse_i,
    input  logic [N-1:0]  sw_set_i,
    input  logic [N-1:0]  sw_clr_i,
    input  logic          mask_we_i,
    input  logic [N-1:0]  mask_wd_i,
    input  logic          prio_we_i,
    input  logic [N-1:0]  prio_wd_i,
    input  logic          ie_set_i,
    input  logic          ie_clr_i,
    input  logic          ack_i,
    input  logic          reti_i,
    input  logic          nmi_i,
    output logic          irq_o,
    output logic [VW-1:0] vec_o,
    output logic          wake_o,
    output logic          ie_o,
    output logic [N-1:0]  flags_o,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  prio_o,
    output logic [1:0]    isr_lvl_o,
    output logic [1:0]    isr_depth_o
);
    logic [N-1:0]    mask_q, prio_q, flags, active, ack_clr;
    logic            ie_q, nmi_pend;
    logic            win_valid, win_hi;
    logic [VW-1:0]   win_idx;
    lvl_e            win_lvl;
    isr_ent_t        top_ent, push_ent;
    logic [SP_W-1:0] depth;
    logic            fwd_nmi, fwd_mask, take, pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            prio_q <= '0;
        end else begin
            if (mask_we_i) mask_q <= mask_wd_i;
            if (prio_we_i) prio_q <= prio_wd_i;
        end
    end

    assign active = flags & ~mask_q;

    pic_resolver #(.N(N), .VW(VW)) u_res (
        .active    (active),
        .prio      (prio_q),
        .win_valid (win_valid),
        .win_hi    (win_hi),
        .win_idx   (win_idx)
    );

    assign win_lvl  = level_of(win_hi);
    assign fwd_nmi  = nmi_pend && (top_ent.lvl != LVL_NMI);
    assign fwd_mask = win_valid && ie_q && (win_lvl > top_ent.lvl);
    assign take     = ack_i && (fwd_nmi || fwd_mask);
    assign pop      = reti_i && !take && (depth != '0);
    assign ack_clr  = (take && !fwd_nmi) ? (N'(1) << win_idx) : '0;

    always_comb begin
        push_ent.lvl = fwd_nmi ? LVL_NMI : win_lvl;
        push_ent.ie  = ie_q;
    end

    pic_flag_bank #(.N(N)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (req_pulse_i | sw_set_i),
        .clr_vec  (sw_clr_i | ack_clr),
        .nmi_set  (nmi_i),
        .nmi_clr  (take && fwd_nmi),
        .flags    (flags),
        .nmi_pend (nmi_pend)
    );

    pic_isr_stack u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (take),
        .push_ent (push_ent),
        .pop      (pop),
        .top_ent  (top_ent),
        .depth    (depth)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ie_q <= 1'b0;
        else if (take)
            ie_q <= 1'b0;
        else if (pop)
            ie_q <= top_ent.ie;
        else if (ie_clr_i)
            ie_q <= 1'b0;
        else if (ie_set_i)
            ie_q <= 1'b1;
    end

    assign irq_o       = fwd_nmi || fwd_mask;
    assign vec_o       = fwd_nmi ? VW'(N) : (fwd_mask ? win_idx : '0);
    assign wake_o      = (|active) || nmi_pend;
    assign ie_o        = ie_q;
    assign flags_o     = flags;
    assign mask_o      = mask_q;
    assign prio_o      = prio_q;
    assign isr_lvl_o   = top_ent.lvl;
    assign isr_depth_o = 2'(depth);
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int N  = 8,
    parameter int VW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          irq,
    input logic [VW-1:0] vec,
    input logic          wake,
    input logic          ie,
    input logic [N-1:0]  flags,
    input logic [N-1:0]  mask,
    input logic [N-1:0]  prio,
    input logic [1:0]    lvl,
    input logic [1:0]    depth,
    input logic          ack
);
    logic          maskable;
    logic [N-1:0]  sel;

    assign maskable = irq && (vec < VW'(N));
    assign sel      = maskable ? (N'(1) << vec) : '0;

    p_reset_state_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == '0 && mask == '1 && !ie && depth == 2'd0));

    p_wake_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ~mask)) |-> wake);

    p_vec_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
        maskable |-> ((sel & mask) == '0 && (sel & flags) != '0));

    p_ie_gate_r5: assert property (@(posedge clk) disable iff (rst)
        maskable |-> ie);

    p_level_order_r6: assert property (@(posedge clk) disable iff (rst)
        (maskable && (sel & prio) == '0) |-> ((flags & ~mask & prio) == '0));

    p_ack_effect_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && irq && depth != 2'd3) |=> (!ie && depth == $past(depth) + 2'd1));

    p_high_block_r8: assert property (@(posedge clk) disable iff (rst)
        (lvl == 2'd2) |-> !maskable);

    p_low_block_r8: assert property (@(posedge clk) disable iff (rst)
        (lvl == 2'd1 && maskable) |-> ((sel & prio) != '0));

    p_nmi_block_r9: assert property (@(posedge clk) disable iff (rst)
        (lvl == 2'd3) |-> !irq);
endmodule

bind prio_irq_ctrl pic_checker #(.N(N), .VW(VW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .irq   (irq_o),
    .vec   (vec_o),
    .wake  (wake_o),
    .ie    (ie_o),
    .flags (flags_o),
    .mask  (mask_o),
    .prio  (prio_o),
    .lvl   (isr_lvl_o),
    .depth (isr_depth_o),
    .ack   (ack_i)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    localparam int N  = 8;
    localparam int VW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] req_pulse = '0, sw_set = '0, sw_clr = '0, mask_wd = '0, prio_wd = '0;
    logic mask_we = 0, prio_we = 0, ie_set = 0, ie_clr = 0, ack = 0, reti = 0, nmi = 0;
    logic irq, wake, ie;
    logic [VW-1:0] vec;
    logic [N-1:0] flags, mask, prio;
    logic [1:0] lvl, depth;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.N(N), .VW(VW)) dut (
        .clk(clk), .rst(rst), .req_pulse_i(req_pulse), .sw_set_i(sw_set), .sw_clr_i(sw_clr),
        .mask_we_i(mask_we), .mask_wd_i(mask_wd), .prio_we_i(prio_we), .prio_wd_i(prio_wd),
        .ie_set_i(ie_set), .ie_clr_i(ie_clr), .ack_i(ack), .reti_i(reti), .nmi_i(nmi),
        .irq_o(irq), .vec_o(vec), .wake_o(wake), .ie_o(ie), .flags_o(flags),
        .mask_o(mask), .prio_o(prio), .isr_lvl_o(lvl), .isr_depth_o(depth)
    );

    typedef struct {
        string         tag;
        logic          irq;
        logic [VW-1:0] vec;
        logic          wake;
        logic          ie;
        logic [N-1:0]  flags;
        logic [1:0]    lvl;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    task automatic tick();
        @(posedge clk);
        #1;
        req_pulse = '0; sw_set = '0; sw_clr = '0; mask_we = 0; prio_we = 0;
        ie_set = 0; ie_clr = 0; ack = 0; reti = 0; nmi = 0;
    endtask

    task automatic ex(string tag, logic e_irq, int e_vec, logic e_wake, logic e_ie,
                      logic [N-1:0] e_fl, int e_lvl);
        exp_t e;
        e.tag = tag; e.irq = e_irq; e.vec = VW'(e_vec); e.wake = e_wake;
        e.ie = e_ie; e.flags = e_fl; e.lvl = 2'(e_lvl);
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (irq !== e.irq || vec !== e.vec || wake !== e.wake || ie !== e.ie ||
                flags !== e.flags || lvl !== e.lvl) begin
                fails++;
                $display("FAIL %s: irq=%b vec=%0d wake=%b ie=%b flags=%h lvl=%0d, expected irq=%b vec=%0d wake=%b ie=%b flags=%h lvl=%0d",
                         e.tag, irq, vec, wake, ie, flags, lvl,
                         e.irq, e.vec, e.wake, e.ie, e.flags, e.lvl);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            finish_run();
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 0;
        tick();
        ex("R11", 0, 0, 0, 0, 8'h00, 0);
        req_pulse = 8'h01; tick();
        ex("R11", 0, 0, 0, 0, 8'h01, 0);
        mask_we = 1; mask_wd = 8'h00; tick();
        ex("R5", 0, 0, 1, 0, 8'h01, 0);            // R3 unmask activates wake
        // R2 single-bit set/clear and set-over-clear
        sw_set = 8'h10; tick();
        ex("R2", 0, 0, 1, 0, 8'h11, 0);
        sw_clr = 8'h01; tick();
        ex("R2", 0, 0, 1, 0, 8'h10, 0);
        sw_clr = 8'h10; req_pulse = 8'h10; tick();
        ex("R2", 0, 0, 1, 0, 8'h10, 0);
        sw_clr = 8'h10; tick();
        ex("R2", 0, 0, 0, 0, 8'h00, 0);
        // R1 collapse of repeated pulses
        req_pulse = 8'h04; tick();
        req_pulse = 8'h04; tick();
        req_pulse = 8'h04; tick();
        ie_set = 1; tick();
        ex("R1", 1, 2, 1, 1, 8'h04, 0);
        ack = 1; tick();
        ex("R7", 0, 0, 0, 0, 8'h00, 1);
        reti = 1; tick();
        ex("R10", 0, 0, 0, 1, 8'h00, 0);           // R1 nothing left pending
        // R6 arbitration
        sw_set = 8'h0A; tick();
        ex("R6", 1, 1, 1, 1, 8'h0A, 0);
        prio_we = 1; prio_wd = 8'h08; tick();
        ex("R6", 1, 3, 1, 1, 8'h0A, 0);
        prio_we = 1; prio_wd = 8'h0A; tick();
        ex("R6", 1, 1, 1, 1, 8'h0A, 0);
        prio_we = 1; prio_wd = 8'h08; sw_clr = 8'h0A; tick();
        ex("R6", 0, 0, 0, 1, 8'h00, 0);
        // R8 nesting
        sw_set = 8'h02; tick();
        ex("R8", 1, 1, 1, 1, 8'h02, 0);
        ack = 1; tick();
        ex("R7", 0, 0, 0, 0, 8'h00, 1);
        ie_set = 1; tick();
        sw_set = 8'h02; tick();
        ex("R8", 0, 0, 1, 1, 8'h02, 1);
        sw_set = 8'h08; tick();
        ex("R8", 1, 3, 1, 1, 8'h0A, 1);
        ack = 1; tick();
        ex("R7", 0, 0, 1, 0, 8'h02, 2);
        ie_set = 1; tick();
        ex("R8", 0, 0, 1, 1, 8'h02, 2);
        // R9 non-maskable
        nmi = 1; tick();
        ex("R9", 1, N, 1, 1, 8'h02, 2);
        ack = 1; tick();
        ex("R9", 0, 0, 1, 0, 8'h02, 3);
        ie_set = 1; tick();
        ex("R9", 0, 0, 1, 1, 8'h02, 3);
        // R10 unwinding
        reti = 1; tick();
        ex("R10", 0, 0, 1, 1, 8'h02, 2);
        reti = 1; tick();
        ex("R10", 0, 0, 1, 1, 8'h02, 1);
        reti = 1; tick();
        ex("R10", 1, 1, 1, 1, 8'h02, 0);
        // R3 mask retains flag
        mask_we = 1; mask_wd = 8'hFF; tick();
        ex("R3", 0, 0, 0, 1, 8'h02, 0);
        mask_we = 1; mask_wd = 8'h00; tick();
        ex("R3", 1, 1, 1, 1, 8'h02, 0);
        reti = 1; tick();
        ex("R10", 1, 1, 1, 1, 8'h02, 0);           // empty-stack return ignored
        // R4 / R12 enable control
        ie_clr = 1; tick();
        ex("R4", 0, 0, 1, 0, 8'h02, 0);
        ie_set = 1; ie_clr = 1; tick();
        ex("R12", 0, 0, 1, 0, 8'h02, 0);
        nmi = 1; tick();
        ex("R9", 1, N, 1, 0, 8'h02, 0);
        ack = 1; ie_set = 1; tick();
        ex("R12", 0, 0, 1, 0, 8'h02, 3);
        reti = 1; tick();
        ex("R10", 0, 0, 1, 0, 8'h02, 0);
        ack = 1; tick();
        ex("R7", 0, 0, 1, 0, 8'h02, 0);            // ack with nothing presented
        tick(); tick();
        done = 1;
        finish_run();
    end
endmodule